// File: doc/BRIEF.md
# I2C Slave Byte Engine

This block is the bit-level slave side of an I2C bus with a 7-bit own address. It oversamples the SCL and SDA lines with the system clock through two-stage synchronisers. It pulls either line low only through an open-drain enable, so the pad or a wired-AND model supplies the high level. It detects Start and Stop, shifts address and data bytes in MSB first, and decides whether each byte is acknowledged. When the master reads, it shifts a host-supplied byte out.

The host side behaves like a small register file. One byte buffer carries received bytes in and transmit bytes out. Status bits report that the buffer is full, that a byte was refused, and the direction of the current transfer. A clock-release bit lets the host end a clock stretch. A single sticky interrupt flag marks every byte event, and can also mark Start and Stop. Only the bus-side behaviour and these host strobes are provided. Ten-bit addressing, master operation and bus timing checks are not part of the block.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset, bufFull, overflow, readMode and irq are 0, clkRelease is 1, and neither line is driven low.
- R2: With startStopIrqEn at 1, a Start and a Stop each set irq. With it at 0, neither does.
- R3: An address byte whose upper seven bits differ from ownAddr gets no acknowledge, does not set irq and leaves the buffer unchanged. The bus is then ignored until the next Start, and data bytes in that time are not acknowledged.
- R4: A matching address byte is acknowledged by pulling SDA low in the ninth clock slot. The whole byte, including the R/W bit in bit 0, is copied into the buffer and bufFull is set. irq is set on the falling edge of the ninth clock.
- R5: After a matching write address (bit 0 = 0), every data byte is acknowledged, copied into the buffer, and sets irq.
- R6: A byte that completes while bufFull or overflow is 1 is not acknowledged and is not copied into the buffer. overflow is set, and irq is still set.
- R7: bufRd clears bufFull, ovfClr alone clears overflow, and irqClr clears irq. A set in the same cycle wins over a clear. A bufRd in the very cycle a byte completes frees the buffer in time, so that byte is accepted.
- R8: With stretchEn at 1, SCL is held low after the ninth clock of each written byte, and clkRelease reads 0, until relClk is pulsed. With stretchEn at 0, written bytes cause no hold.
- R9: A matching read address (bit 0 = 1) sets readMode, is acknowledged, clears clkRelease and holds SCL low whatever stretchEn is.
- R10: bufWr loads both the buffer and the transmit shifter and sets bufFull. The byte goes out MSB first. SDA changes only while SCL is low. bufFull clears when the eighth bit has been sent.
- R11: The master's acknowledge is sampled on the ninth rising SCL edge. A low level sets irq and holds SCL low again for the next byte. A high level clears readMode, releases both lines and waits for a Start.
- R12: A Start in the middle of a byte restarts bit counting, so the address that follows is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Level seen on the SCL line |
| sdaIn | input | 1 | Level seen on the SDA line |
| sclDriveLow | output | 1 | Open-drain enable pulling SCL low |
| sdaDriveLow | output | 1 | Open-drain enable pulling SDA low |
| ownAddr | input | 7 | Own 7-bit slave address |
| stretchEn | input | 1 | Hold SCL after each written byte |
| startStopIrqEn | input | 1 | Start and Stop also set irq |
| hostWdata | input | 8 | Byte written by bufWr |
| bufWr | input | 1 | Write strobe for the buffer and transmit shifter |
| bufRd | input | 1 | Read strobe for the buffer, clears bufFull |
| relClk | input | 1 | Sets clkRelease, ending a clock hold |
| ovfClr | input | 1 | Clears overflow |
| irqClr | input | 1 | Clears irq |
| bufData | output | 8 | Buffer contents |
| bufFull | output | 1 | Buffer holds an unread or unsent byte |
| overflow | output | 1 | A byte was refused |
| readMode | output | 1 | Current transfer is a master read |
| clkRelease | output | 1 | 0 while SCL is being held |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A host read of the buffer can land in the same system cycle as the byte decision that follows the eighth falling SCL edge. The bench provokes this by counting the two synchroniser stages and the edge register, then pulsing bufRd in exactly that cycle while the buffer still holds an unread byte. The expected result is that the new byte is acknowledged and stored, bufFull stays set and overflow stays clear. A design that looked at the stale full flag would refuse the byte instead. Around this case the bench sweeps every 7-bit address against a fixed own address, every data byte value for writes, and a run of computed values for reads.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX,
    ST_IGNORE
  } busState_e;

  // strobes from the bus control to the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // take the sampled SDA bit into the shifter
    logic shiftOut;   // advance the transmit shifter
    logic loadBuf;    // copy shifter into buffer, mark full
    logic setOvf;     // byte refused
    logic setIrq;     // raise interrupt flag
    logic setRead;    // transfer is a master read
    logic clrRead;    // leave read direction
    logic holdScl;    // start a clock hold
    logic clrFullTx;  // transmit byte has left
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              stretchEn,
  input  logic              ssIrqEn,
  input  logic [DATA_W-1:0] shiftQ,
  input  logic              bufFull,
  input  logic              overflow,
  input  logic              bufRd,
  output dpStrobe_t         strb,
  output logic              sdaBit,
  output logic              sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W + 1);

  // line synchronisers
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS   = sclPipe[SYNC_STAGES-1];
  assign sdaS   = sdaPipe[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startEv = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv  = sclS & sclQ & ~sdaQ & sdaS;

  // control state
  busState_e        state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic ackDrive, ackN;
  logic txOn, txN;
  logic byteOk, okN;
  logic rdAddr, rdAddrN;
  logic mNack, mNackN;

  logic blocked, addrHit;
  assign blocked = (bufFull & ~bufRd) | overflow;
  assign addrHit = (shiftQ[DATA_W-1:1] == ownAddr);

  always_comb begin
    strb    = '0;
    stateN  = state;
    cntN    = cnt;
    ackN    = ackDrive;
    txN     = txOn;
    okN     = byteOk;
    rdAddrN = rdAddr;
    mNackN  = mNack;
    if (startEv || stopEv) begin
      stateN       = startEv ? ST_ADDR : ST_IDLE;
      cntN         = '0;
      ackN         = 1'b0;
      txN          = 1'b0;
      okN          = 1'b0;
      strb.setIrq  = ssIrqEn;
      strb.clrRead = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && cnt != ACK_SLOT) begin
            strb.shiftIn = (cnt < LAST_BIT);
            cntN         = cnt + 1'b1;
          end
          if (sclFall && cnt == LAST_BIT) begin
            if (state == ST_ADDR && !addrHit) begin
              stateN = ST_IGNORE;
              cntN   = '0;
            end else begin
              okN     = 1'b1;
              rdAddrN = (state == ST_ADDR) & shiftQ[0];
              if (blocked) begin
                strb.setOvf = 1'b1;
              end else begin
                strb.loadBuf = 1'b1;
                ackN         = 1'b1;
              end
            end
          end
          if (sclFall && cnt == ACK_SLOT) begin
            ackN        = 1'b0;
            okN         = 1'b0;
            cntN        = '0;
            strb.setIrq = byteOk;
            if (state == ST_ADDR) begin
              if (!ackDrive) begin
                stateN = ST_IGNORE;
              end else if (rdAddr) begin
                stateN       = ST_TX;
                txN          = 1'b1;
                strb.setRead = 1'b1;
                strb.holdScl = 1'b1;
              end else begin
                stateN       = ST_RX;
                strb.holdScl = stretchEn;
              end
            end else begin
              strb.holdScl = stretchEn;
            end
          end
        end
        ST_TX: begin
          if (sclRise && cnt != ACK_SLOT) begin
            cntN = cnt + 1'b1;
            if (cnt == LAST_BIT) mNackN = sdaS;
          end
          if (sclFall) begin
            if (cnt != '0 && cnt < LAST_BIT) strb.shiftOut = 1'b1;
            if (cnt == LAST_BIT) begin
              txN            = 1'b0;
              strb.clrFullTx = 1'b1;
            end
            if (cnt == ACK_SLOT) begin
              cntN = '0;
              if (!mNack) begin
                txN          = 1'b1;
                strb.setIrq  = 1'b1;
                strb.holdScl = 1'b1;
              end else begin
                stateN       = ST_IDLE;
                strb.clrRead = 1'b1;
              end
            end
          end
        end
        ST_IDLE, ST_IGNORE: begin
          cntN = '0;
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ackDrive <= 1'b0;
      txOn     <= 1'b0;
      byteOk   <= 1'b0;
      rdAddr   <= 1'b0;
      mNack    <= 1'b0;
    end else begin
      state    <= stateN;
      cnt      <= cntN;
      ackDrive <= ackN;
      txOn     <= txN;
      byteOk   <= okN;
      rdAddr   <= rdAddrN;
      mNack    <= mNackN;
    end
  end

  assign sdaDriveLow = ackDrive | (txOn & ~shiftQ[DATA_W-1]);

  // R10: transmit level is steady through every SCL high phase
  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && sclS && sclQ && $past(sclS)) |-> $stable(sdaDriveLow));

  // R6: a refused byte never gets an acknowledge
  p_nack_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ADDR || state == ST_RX) && sclFall && !startEv && !stopEv
      && cnt == LAST_BIT && blocked) |=> !ackDrive);

  // R3: an ignored transfer leaves SDA alone
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaDriveLow);

endmodule

// File: rtl/i2cs_dpath.sv
module i2cs_dpath
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              bufWr,
  input  logic              bufRd,
  input  logic              relClk,
  input  logic              ovfClr,
  input  logic              irqClr,
  output logic [DATA_W-1:0] shiftQ,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              readMode,
  output logic              clkRelease,
  output logic              irq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ     <= '0;
      bufData    <= '0;
      bufFull    <= 1'b0;
      overflow   <= 1'b0;
      readMode   <= 1'b0;
      clkRelease <= 1'b1;
      irq        <= 1'b0;
    end else begin
      if (bufWr)              shiftQ <= hostWdata;
      else if (strb.shiftIn)  shiftQ <= {shiftQ[DATA_W-2:0], sdaBit};
      else if (strb.shiftOut) shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};

      if (strb.loadBuf) bufData <= shiftQ;
      else if (bufWr)   bufData <= hostWdata;

      if (strb.loadBuf || bufWr)         bufFull <= 1'b1;
      else if (bufRd || strb.clrFullTx)  bufFull <= 1'b0;

      if (strb.setOvf)   overflow <= 1'b1;
      else if (ovfClr)   overflow <= 1'b0;

      if (strb.setIrq)   irq <= 1'b1;
      else if (irqClr)   irq <= 1'b0;

      if (strb.setRead)      readMode <= 1'b1;
      else if (strb.clrRead) readMode <= 1'b0;

      if (strb.holdScl)  clkRelease <= 1'b0;
      else if (relClk)   clkRelease <= 1'b1;
    end
  end

  // R7: overflow is sticky until the host clears it
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);

  // R7: interrupt flag is sticky until the host clears it
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  // R8: a clock hold ends only on the host release strobe
  p_release_by_host_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRelease) |-> $past(relClk));

  // R9: entering read direction always comes with a clock hold
  p_read_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readMode) |-> !clkRelease);

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              stretchEn,
  input  logic              startStopIrqEn,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              bufWr,
  input  logic              bufRd,
  input  logic              relClk,
  input  logic              ovfClr,
  input  logic              irqClr,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              readMode,
  output logic              clkRelease,
  output logic              irq
);

  dpStrobe_t         strb;
  logic [DATA_W-1:0] shiftQ;
  logic              sdaBit;

  i2cs_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .ownAddr    (ownAddr),
    .stretchEn  (stretchEn),
    .ssIrqEn    (startStopIrqEn),
    .shiftQ     (shiftQ),
    .bufFull    (bufFull),
    .overflow   (overflow),
    .bufRd      (bufRd),
    .strb       (strb),
    .sdaBit     (sdaBit),
    .sdaDriveLow(sdaDriveLow)
  );

  i2cs_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sdaBit    (sdaBit),
    .hostWdata (hostWdata),
    .bufWr     (bufWr),
    .bufRd     (bufRd),
    .relClk    (relClk),
    .ovfClr    (ovfClr),
    .irqClr    (irqClr),
    .shiftQ    (shiftQ),
    .bufData   (bufData),
    .bufFull   (bufFull),
    .overflow  (overflow),
    .readMode  (readMode),
    .clkRelease(clkRelease),
    .irq       (irq)
  );

  assign sclDriveLow = ~clkRelease;

endmodule

// File: tb/i2c_slave_engine_test.sv
module i2c_slave_engine_test;

  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic mScl, mSda;
  logic sclLine, sdaLine;
  logic sclDriveLow, sdaDriveLow;
  logic [6:0] ownAddr;
  logic stretchEn, startStopIrqEn;
  logic [7:0] hostWdata;
  logic bufWr, bufRd, relClk, ovfClr, irqClr;
  logic [7:0] bufData;
  logic bufFull, overflow, readMode, clkRelease, irq;

  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_slave_engine uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .ownAddr(ownAddr), .stretchEn(stretchEn), .startStopIrqEn(startStopIrqEn),
    .hostWdata(hostWdata), .bufWr(bufWr), .bufRd(bufRd), .relClk(relClk),
    .ovfClr(ovfClr), .irqClr(irqClr), .bufData(bufData), .bufFull(bufFull),
    .overflow(overflow), .readMode(readMode), .clkRelease(clkRelease), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
  endtask

  task automatic host(input int which);
    case (which)
      0: bufRd = 1'b1;
      1: irqClr = 1'b1;
      2: ovfClr = 1'b1;
      default: relClk = 1'b1;
    endcase
    @(negedge clk);
    bufRd = 1'b0; irqClr = 1'b0; ovfClr = 1'b0; relClk = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] v);
    hostWdata = v;
    bufWr = 1'b1;
    @(negedge clk);
    bufWr = 1'b0;
  endtask

  task automatic sendStart();
    mSda = 1'b1; waitN(H);
    sclHigh(); waitN(H);
    mSda = 1'b0; waitN(H);
    mScl = 1'b0; waitN(H);
  endtask

  task automatic sendStop();
    mSda = 1'b0; waitN(H);
    sclHigh(); waitN(H);
    mSda = 1'b1; waitN(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitN(H);
      sclHigh(); waitN(H);
      mScl = 1'b0; waitN(3);
    end
  endtask

  // rdAtEnd pulses bufRd in the cycle the slave decides on the byte
  task automatic writeByte(input logic [7:0] b, input bit rdAtEnd, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitN(H);
      sclHigh(); waitN(H);
      mScl = 1'b0;
      if (i == 0 && rdAtEnd) begin
        waitN(2); bufRd = 1'b1; waitN(1); bufRd = 1'b0;
      end else begin
        waitN(3);
      end
    end
    mSda = 1'b1; waitN(H);
    sclHigh(); waitN(2);
    ack = sdaLine;
    waitN(H);
    mScl = 1'b0; waitN(H);
  endtask

  task automatic readByte(input logic nack, output logic [7:0] b, output int unsteady);
    unsteady = 0;
    for (int i = 7; i >= 0; i--) begin
      waitN(H);
      sclHigh(); waitN(2);
      b[i] = sdaLine;
      waitN(H);
      if (sdaLine !== b[i]) unsteady++;
      mScl = 1'b0;
    end
    waitN(H);
    mSda = nack; waitN(H);
    sclHigh(); waitN(H);
    mScl = 1'b0; waitN(H);
    mSda = 1'b1;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [7:0] expBuf;
    int unst;
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1; ownAddr = OWN;
    stretchEn = 1'b0; startStopIrqEn = 1'b0; hostWdata = '0;
    bufWr = 0; bufRd = 0; relClk = 0; ovfClr = 0; irqClr = 0;
    expBuf = '0;
    waitN(5);
    rstN = 1'b1;
    waitN(3);

    // R1 reset state
    chk("R1 bufFull", bufFull, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irq", irq, 0);
    chk("R1 readMode", readMode, 0);
    chk("R1 clkRelease", clkRelease, 1);
    chk("R1 lines", {sclDriveLow, sdaDriveLow}, 0);

    // R2 start/stop interrupts
    startStopIrqEn = 1'b1;
    sendStart();
    chk("R2 start irq", irq, 1);
    host(1);
    sendStop();
    chk("R2 stop irq", irq, 1);
    host(1);
    startStopIrqEn = 1'b0;
    sendStart();
    chk("R2 start no irq", irq, 0);
    sendStop();
    chk("R2 stop no irq", irq, 0);

    // R3/R4/R5 sweep every address
    for (int a = 0; a < 128; a++) begin
      sendStart();
      writeByte({a[6:0], 1'b0}, 1'b0, ack);
      if (a[6:0] == OWN) begin
        expBuf = {a[6:0], 1'b0};
        chk("R4 addr ack", ack, 0);
        chk("R4 addr irq", irq, 1);
        chk("R4 addr buf", bufData, expBuf);
        chk("R4 addr full", bufFull, 1);
        host(0); host(1);
        writeByte(8'hC3, 1'b0, ack);
        expBuf = 8'hC3;
        chk("R5 data ack", ack, 0);
        chk("R5 data buf", bufData, expBuf);
      end else begin
        chk("R3 miss nack", ack, 1);
        chk("R3 miss irq", irq, 0);
        writeByte({OWN, 1'b0}, 1'b0, ack);
        chk("R3 ignored data nack", ack, 1);
        chk("R3 buf unchanged", bufData, expBuf);
        chk("R3 no full", bufFull, 0);
      end
      sendStop();
      host(0); host(1);
    end

    // R5 sweep every data value, no stretch (R8)
    sendStart();
    writeByte({OWN, 1'b0}, 1'b0, ack);
    host(0); host(1);
    for (int v = 0; v < 256; v++) begin
      writeByte(v[7:0], 1'b0, ack);
      chk("R5 sweep ack", ack, 0);
      chk("R5 sweep buf", bufData, v);
      chk("R5 sweep irq", irq, 1);
      if (v == 0) chk("R8 no hold when disabled", sclDriveLow, 0);
      host(0); host(1);
    end

    // R6 refused bytes
    writeByte(8'h5E, 1'b0, ack);
    writeByte(8'h11, 1'b0, ack);
    chk("R6 full nack", ack, 1);
    chk("R6 overflow set", overflow, 1);
    chk("R6 buf kept", bufData, 8'h5E);
    chk("R6 irq still", irq, 1);
    host(0); host(1);
    chk("R7 read clears full", bufFull, 0);
    chk("R7 overflow sticky", overflow, 1);
    writeByte(8'h22, 1'b0, ack);
    chk("R6 overflow nack", ack, 1);
    chk("R6 buf kept again", bufData, 8'h5E);
    host(2);
    chk("R7 ovfClr", overflow, 0);
    writeByte(8'h33, 1'b0, ack);
    chk("R6 accepted after clear", ack, 0);
    chk("R6 buf new", bufData, 8'h33);

    // R7 collision: read lands in the decision cycle
    writeByte(8'h44, 1'b1, ack);
    chk("R7 collide ack", ack, 0);
    chk("R7 collide buf", bufData, 8'h44);
    chk("R7 collide full", bufFull, 1);
    chk("R7 collide ovf", overflow, 0);
    host(0); host(1);
    chk("R7 irqClr", irq, 0);
    sendStop();

    // R8 stretching on writes
    stretchEn = 1'b1;
    sendStart();
    writeByte({OWN, 1'b0}, 1'b0, ack);
    chk("R8 addr hold", sclDriveLow, 1);
    host(0); host(1); host(3);
    chk("R8 addr released", sclDriveLow, 0);
    writeByte(8'h96, 1'b0, ack);
    waitN(20);
    chk("R8 data hold", sclDriveLow, 1);
    chk("R8 clkRelease low", clkRelease, 0);
    chk("R8 data buf", bufData, 8'h96);
    host(0); host(1); host(3);
    chk("R8 data released", {sclDriveLow, clkRelease}, 1);
    sendStop();
    stretchEn = 1'b0;

    // R9/R10/R11 reads
    sendStart();
    writeByte({OWN, 1'b1}, 1'b0, ack);
    chk("R9 read ack", ack, 0);
    chk("R9 readMode", readMode, 1);
    chk("R9 hold", sclDriveLow, 1);
    chk("R9 clkRelease", clkRelease, 0);
    chk("R9 addr buf", bufData, {OWN, 1'b1});
    host(0); host(1);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] tv;
      tv = 8'((i * 37 + 5) ^ (i << 4));
      hostWrite(tv);
      chk("R10 write full", bufFull, 1);
      host(3);
      readByte(i == 15, rb, unst);
      chk("R10 read value", rb, tv);
      chk("R10 sda steady", unst, 0);
      chk("R10 full cleared", bufFull, 0);
      if (i < 15) begin
        chk("R11 ack irq", irq, 1);
        chk("R11 ack hold", sclDriveLow, 1);
        host(1);
      end else begin
        chk("R11 nack readMode", readMode, 0);
        chk("R11 nack lines", {sclDriveLow, sdaDriveLow}, 0);
      end
    end
    sendStop();

    // R12 start in the middle of a byte
    sendStart();
    sendBits(8'hA0, 4);
    sendStart();
    writeByte({OWN, 1'b0}, 1'b0, ack);
    chk("R12 restart ack", ack, 0);
    chk("R12 restart buf", bufData, {OWN, 1'b0});
    sendStop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule